// File: doc/BRIEF.md
# Validity-Gated Clock Source Selector

This block decides which clock source feeds the processor, high-speed bus and peripheral bus domains. One selection value covers all three domains, so they always move together. Software writes the index of the wanted source through a small synchronous register port. The block accepts the write only when that source is enabled and known to be good. Otherwise it keeps the current source and raises a sticky error flag.

The block recomputes a validity vector on every cycle. A source with a hardware monitor counts as valid when it is enabled and its monitor flag is high. The two external clock inputs and the low-frequency internal oscillator have no monitor. They count as valid as soon as they are enabled. If the selected source goes invalid, the block falls back to the main oscillator input and records the event in a second sticky flag. The output is a one-hot vector naming the source in use. The real multiplexer, its glitch filtering and the PLL lock logic sit outside this block. Their effects arrive only as enables and monitor flags.

Top module: `clk_src_gate_sel`

## Requirements
- R1: After reset, the selection is index 0 (the main oscillator input), `active_src` equals 7'b0000001, and both flags read 0.
- R2: Status bit i equals `src_en[i] & (src_mon[i] | U[i])`. Here U marks the unmonitored sources: index 2 (external input A), index 3 (low-frequency internal oscillator) and index 6 (external input B). Index 1 is the first PLL output. The vector reads at address 1 in bits [6:0], with bit 7 zero.
- R3: `active_src` is always one-hot, and its set bit is the selected index.
- R4: A write to address 0 with `reg_wdata[2:0]` = k and `reg_wdata[7:3]` = 0, where k < 7 and status bit k is 1, makes k the selection from the next cycle.
- R5: A write to address 0 that names a source with status 0, an index of 7, or nonzero bits [7:3] leaves the selection unchanged. It also sets the error flag (bit 0 at address 2).
- R6: If the selection is nonzero, its status bit is 0, and no write is accepted in that cycle, the selection becomes 0 on the next cycle. The fallback flag (bit 1 at address 2) is also set.
- R7: An accepted write takes priority over a fallback in the same cycle: the new source is taken and the fallback flag is not set.
- R8: A write to address 2 clears every flag whose `reg_wdata` bit is 1. A flag set in the same cycle as its clear stays 1. Otherwise the flags hold.
- R9: `reg_rdata` updates one cycle after `reg_addr` is presented and shows state as it stood before that edge. Address 0 returns the selection in bits [2:0] and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 7 | Per-source enable |
| src_mon | input | 7 | Per-source monitor good flag |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| active_src | output | 7 | One-hot selected source |

## Verification
The hardest case to reach is an accepted write and a loss of validity on the current source in the same clock cycle. It needs a valid target, a failing current source and a write strobe all at once. Directed steps build this case by hand: the monitor of the selected PLL drops on the cycle that a write moves to another valid source. A second directed step does the same with a fallback and a flag clear in one cycle. The random phase keeps most enables and monitors high, with rare drops. This keeps many non-default sources selected long enough for losses to hit them.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int SRC_CNT  = 7;
    localparam int REG_W    = 8;

    // source indices; bit 1 is the first PLL output
    typedef enum logic [2:0] {
        SRC_MAIN_OSC = 3'd0,
        SRC_PLL_A    = 3'd1,
        SRC_EXT_A    = 3'd2,
        SRC_LF_OSC   = 3'd3,
        SRC_HF_OSC   = 3'd4,
        SRC_PLL_B    = 3'd5,
        SRC_EXT_B    = 3'd6
    } src_id_e;

    // sources that are valid by rule once enabled
    localparam logic [SRC_CNT-1:0] UNMON_MASK =
        (SRC_CNT'(1) << SRC_EXT_A) | (SRC_CNT'(1) << SRC_LF_OSC) | (SRC_CNT'(1) << SRC_EXT_B);

    typedef enum logic [1:0] {
        RA_SEL   = 2'd0,
        RA_STAT  = 2'd1,
        RA_FLAGS = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic fallback;   // bit 1
        logic reject;     // bit 0
    } sel_flags_t;

endpackage

// File: rtl/clksel_valid.sv
module clksel_valid #(
    parameter int                N_SRC = 7,
    parameter logic [N_SRC-1:0]  UNMON = '0
) (
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] mon,
    output logic [N_SRC-1:0] valid
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (UNMON[i]) begin : g_rule
            assign valid[i] = en[i];
        end else begin : g_meas
            assign valid[i] = en[i] & mon[i];
        end
    end
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter  int N_SRC  = SRC_CNT,
    parameter  int DATA_W = REG_W,
    parameter  int DFLT   = 0,
    localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  valid,
    input  logic              wr_sel,
    input  logic              wr_flags,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEL_W-1:0]  sel,
    output sel_flags_t        flags
);
    logic [SEL_W-1:0] sel_q;
    sel_flags_t       flags_q;
    logic [SEL_W-1:0] tgt;
    logic             hi_zero, tgt_ok, cur_ok, accept, reject, lost;
    logic [1:0]       clr;

    assign tgt     = wdata[SEL_W-1:0];
    assign hi_zero = (wdata[DATA_W-1:SEL_W] == '0);
    assign clr     = wr_flags ? wdata[1:0] : 2'b00;

    always_comb begin
        tgt_ok = 1'b0;
        cur_ok = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (tgt == SEL_W'(i))   tgt_ok = valid[i];
            if (sel_q == SEL_W'(i)) cur_ok = valid[i];
        end
    end

    assign accept = wr_sel & tgt_ok & hi_zero;
    assign reject = wr_sel & ~accept;
    assign lost   = (sel_q != SEL_W'(DFLT)) & ~cur_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= SEL_W'(DFLT);
            flags_q <= '0;
        end else begin
            if (accept)    sel_q <= tgt;
            else if (lost) sel_q <= SEL_W'(DFLT);
            flags_q.reject   <= reject | (flags_q.reject & ~clr[0]);
            flags_q.fallback <= (lost & ~accept) | (flags_q.fallback & ~clr[1]);
        end
    end

    assign sel   = sel_q;
    assign flags = flags_q;

    a_r4_take_valid: assert property (@(posedge clk) disable iff (rst)
        accept |=> sel_q == $past(tgt));
    a_r5_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
        (reject && !lost) |=> (sel_q == $past(sel_q)) && flags_q.reject);
    a_r6_fall_back: assert property (@(posedge clk) disable iff (rst)
        (lost && !wr_sel) |=> (sel_q == SEL_W'(DFLT)) && flags_q.fallback);
    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        (lost && accept && !flags_q.fallback) |=> !flags_q.fallback);
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q.reject && !clr[0]) |=> flags_q.reject);
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int N_SRC  = SRC_CNT,
    parameter int DATA_W = REG_W,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_SRC-1:0]  valid,
    input  sel_flags_t        flags,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rd_d;

    always_comb begin
        unique case (reg_addr_e'(addr))
            RA_SEL:   rd_d = DATA_W'(sel);
            RA_STAT:  rd_d = DATA_W'(valid);
            RA_FLAGS: rd_d = DATA_W'(flags);
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign rdata = rd_q;

    a_r9_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_NONE) |=> rd_q == '0);
    a_r9_sel_readback: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_SEL) |=> rd_q == DATA_W'($past(sel)));
endmodule

// File: rtl/clk_src_gate_sel.sv
module clk_src_gate_sel
    import clksel_pkg::*;
#(
    parameter  int               N_SRC  = SRC_CNT,
    parameter  int               DATA_W = REG_W,
    parameter  logic [N_SRC-1:0] UNMON  = UNMON_MASK,
    parameter  int               DFLT   = SRC_MAIN_OSC,
    localparam int               SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_en,
    input  logic [N_SRC-1:0]  src_mon,
    input  logic [1:0]        reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_SRC-1:0]  active_src
);
    logic [N_SRC-1:0] src_valid;
    logic [SEL_W-1:0] sel;
    sel_flags_t       flags;
    logic             wr_sel, wr_flags;

    assign wr_sel   = reg_we & (reg_addr == RA_SEL);
    assign wr_flags = reg_we & (reg_addr == RA_FLAGS);

    clksel_valid #(.N_SRC(N_SRC), .UNMON(UNMON)) u_valid (
        .en(src_en), .mon(src_mon), .valid(src_valid)
    );

    clksel_ctrl #(.N_SRC(N_SRC), .DATA_W(DATA_W), .DFLT(DFLT)) u_ctrl (
        .clk(clk), .rst(rst), .valid(src_valid),
        .wr_sel(wr_sel), .wr_flags(wr_flags), .wdata(reg_wdata),
        .sel(sel), .flags(flags)
    );

    clksel_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .sel(sel),
        .valid(src_valid), .flags(flags), .rdata(reg_rdata)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_hot
        assign active_src[i] = (sel == SEL_W'(i));
        if (UNMON[i]) begin : g_um
            a_r2_rule_valid: assert property (@(posedge clk) disable iff (rst)
                src_en[i] |-> src_valid[i]);
        end
    end

    a_r3_one_hot: assert property (@(posedge clk) disable iff (rst)
        $countones(active_src) == 1);
endmodule

// File: tb/sim_clk_src_gate_sel.sv
module sim_clk_src_gate_sel;
    localparam logic [6:0] UM = 7'b1001100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] src_en = '0, src_mon = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] active_src;

    int checks = 0, errors = 0;
    int m_sel = 0;
    logic m_err = 1'b0, m_fb = 1'b0;
    logic [7:0] m_rd = '0;

    always #4 clk = ~clk;

    clk_src_gate_sel u0 (
        .clk(clk), .rst(rst), .src_en(src_en), .src_mon(src_mon),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .active_src(active_src)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] vld(input logic [6:0] en, input logic [6:0] mon);
        return en & (mon | UM);
    endfunction

    task automatic step(input logic [6:0] en, input logic [6:0] mon, input logic we,
                        input logic [1:0] a, input logic [7:0] wd, input string tag);
        logic [6:0] v;
        logic acc, rej, lost;
        int nsel;
        src_en = en; src_mon = mon; reg_we = we; reg_addr = a; reg_wdata = wd;
        v    = vld(en, mon);
        acc  = we && a == 2'd0 && wd[7:3] == 0 && wd[2:0] < 3'd7 && v[wd[2:0]];
        rej  = we && a == 2'd0 && !acc;
        lost = (m_sel != 0) && !v[m_sel];
        case (a)
            2'd0:    m_rd = 8'(m_sel);
            2'd1:    m_rd = {1'b0, v};
            2'd2:    m_rd = {6'd0, m_fb, m_err};
            default: m_rd = 8'd0;
        endcase
        nsel = acc ? int'(wd[2:0]) : (lost ? 0 : m_sel);
        m_err = rej | (m_err & !(we && a == 2'd2 && wd[0]));
        m_fb  = (lost & !acc) | (m_fb & !(we && a == 2'd2 && wd[1]));
        m_sel = nsel;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        chk(active_src == (7'(1) << m_sel), {tag, " R3 active"}, active_src, 7'(1) << m_sel);
        chk(reg_rdata == m_rd, {tag, " R9 rdata"}, reg_rdata, m_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c10c));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(active_src == 7'b0000001, "R1 reset active", active_src, 1);
        chk(reg_rdata == 8'd0, "R1 reset rdata", reg_rdata, 0);
        step(7'h7F, 7'h7F, 0, 2'd2, 8'd0, "R1 flags");
        chk(reg_rdata == 8'd0, "R1 flags clear", reg_rdata, 0);
        // R2: monitors low, only rule-valid sources report
        step(7'h7F, 7'h00, 0, 2'd1, 8'd0, "R2 status");
        chk(reg_rdata == 8'h4C, "R2 status unmonitored", reg_rdata, 8'h4C);
        step(7'h7F, 7'h00, 1, 2'd0, 8'd3, "R4 take lf osc");
        chk(active_src == 7'b0001000, "R4 select 3", active_src, 7'b0001000);
        step(7'h7F, 7'h00, 1, 2'd0, 8'd1, "R5 pll invalid");
        chk(active_src == 7'b0001000, "R5 kept", active_src, 7'b0001000);
        step(7'h7F, 7'h7F, 1, 2'd0, 8'd7, "R5 index 7");
        step(7'h7F, 7'h7F, 1, 2'd0, 8'h12, "R5 high bits");
        chk(active_src == 7'b0001000, "R5 high bits kept", active_src, 7'b0001000);
        step(7'h7F, 7'h7F, 0, 2'd2, 8'd0, "R5 flag read");
        chk(reg_rdata == 8'd1, "R5 error flag", reg_rdata, 1);
        step(7'h7F, 7'h7F, 1, 2'd2, 8'd1, "R8 clear");
        step(7'h7F, 7'h7F, 0, 2'd2, 8'd0, "R8 read");
        chk(reg_rdata == 8'd0, "R8 cleared", reg_rdata, 0);
        step(7'h7F, 7'h7F, 1, 2'd0, 8'd5, "R4 take pll b");
        step(7'h7F, 7'h5F, 0, 2'd0, 8'd0, "R6 lose pll b");
        chk(active_src == 7'b0000001, "R6 fell back", active_src, 1);
        step(7'h7F, 7'h7F, 0, 2'd2, 8'd0, "R6 flag read");
        chk(reg_rdata == 8'd2, "R6 fallback flag", reg_rdata, 2);
        step(7'h7F, 7'h7F, 1, 2'd2, 8'd3, "R8 clear both");
        step(7'h7F, 7'h7F, 1, 2'd0, 8'd1, "R7 take pll a");
        step(7'h7F, 7'h7D, 1, 2'd0, 8'd4, "R7 loss and write");
        chk(active_src == 7'b0010000, "R7 write wins", active_src, 7'b0010000);
        step(7'h7F, 7'h7F, 0, 2'd2, 8'd0, "R7 flag read");
        chk(reg_rdata == 8'd0, "R7 no fallback flag", reg_rdata, 0);
        step(7'h7F, 7'h6F, 1, 2'd2, 8'd2, "R8 set beats clear");
        step(7'h7F, 7'h7F, 0, 2'd2, 8'd0, "R8 read set");
        chk(reg_rdata == 8'd2, "R8 set wins", reg_rdata, 2);
        step(7'h7F, 7'h7F, 0, 2'd3, 8'd0, "R9 addr 3");
        chk(reg_rdata == 8'd0, "R9 addr 3 zero", reg_rdata, 0);
        step(7'h3F, 7'h00, 1, 2'd0, 8'd6, "R5 ext b disabled");
        step(7'h7F, 7'h00, 1, 2'd0, 8'd6, "R2 ext b by rule");
        chk(active_src == 7'b1000000, "R2 ext b selected", active_src, 7'b1000000);

        for (int n = 0; n < 600; n++) begin
            logic [6:0] en, mon;
            logic [1:0] a;
            logic [7:0] wd;
            en  = 7'(~($urandom & $urandom & $urandom));
            mon = 7'(~($urandom & $urandom & $urandom));
            a   = 2'($urandom);
            wd  = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 8);
            step(en, mon, 1'($urandom), a, wd, "rand");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule